// File: doc/BRIEF.md
# Load/Store Alignment and Lane Unit

This block sits between an execute stage and a 32-bit data memory port. Each request carries a 6-bit memory opcode, a base register value, a register offset, a 16-bit immediate offset and store data. The block adds the base and the chosen offset to form the effective address. It forces natural alignment for the access size and drives a byte-enable mask to the memory. For stores it also places the data on the proper byte lanes.

Misaligned halfword and word addresses are not trapped. They are rounded down to the size boundary. Memory is big-endian. When a load is issued, the block remembers its size and byte offset. When the memory signals ready, the block selects the addressed lane, zero-extends it to 32 bits and presents the result with a one-cycle valid pulse. Only one load may be outstanding, so new requests are held off until the returned data is taken.

Top module: `mem_lane_unit`

## Requirements
- R1: An opcode is accepted only when bits [5:4] are 2'b11 and bits [1:0] are not 2'b11. Bit 2 selects store (1) or load (0) and bit 3 selects the immediate offset (1) or the register offset (0). Bits [1:0] give the size: 00 byte, 01 halfword, 10 word. For any other opcode, or with `req_valid` low, `mem_req` stays low and `mem_be` is 4'b0000.
- R2: The effective address is `base_val + reg_off`, or `base_val` plus `imm_off` sign-extended to 32 bits.
- R3: A byte access drives the effective address unmodified on `mem_addr`.
- R4: A halfword access clears address bit 0, and a word access clears address bits 1 and 0.
- R5: `mem_be[3]` enables bits 31:24 (address offset 0) and `mem_be[0]` enables bits 7:0 (offset 3). A byte access sets one bit, a halfword two bits (4'b1100 at offset 0, 4'b0011 at offset 2), and a word all four.
- R6: Store data is replicated across lanes: a byte store drives `{4{d[7:0]}}`, a halfword store `{2{d[15:0]}}`, and a word store `d`. `mem_we` equals opcode bit 2 during a request.
- R7: A load result is the addressed big-endian lane, zero-extended: a byte at offset k comes from bits [31-8k:24-8k], and a halfword comes from bits 31:16 at offset 0 or 15:0 at offset 2.
- R8: `load_valid` is high for exactly one cycle, in the cycle after the cycle in which `mem_ready` is sampled high while a load is outstanding. `load_data` holds its value until the next completion.
- R9: While a load is outstanding, `mem_req` stays low whatever the request inputs are. A `mem_ready` with no load outstanding produces no `load_valid` and leaves `load_data` unchanged.
- R10: After reset `mem_req` and `load_valid` are low and `load_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| opcode | input | 6 | Memory opcode (size, direction, offset select) |
| base_val | input | 32 | Base register value |
| reg_off | input | 32 | Register offset |
| imm_off | input | 16 | Immediate offset, sign-extended |
| store_data | input | 32 | Data to store |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write strobe qualifier |
| mem_addr | output | 32 | Aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_ready | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| load_valid | output | 1 | One-cycle load result strobe |
| load_data | output | 32 | Zero-extended load result |

## Verification
The hardest state to reach from the ports is a request arriving while a load is still waiting for its data. Reaching it needs a load issued with `mem_ready` deliberately held low for several cycles while another legal request is presented. The bench builds that case, checks that `mem_req` stays low, and then releases ready to check for a single valid pulse. A stray ready pulse with nothing outstanding follows; the check is that `load_data` holds its value and no pulse appears. Halfword lane selection is checked with the sign bit of the lane set, so a sign-extending fault would show.

// File: rtl/mlu_pkg.sv
package mlu_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_NONE = 2'b11
   } size_e;

   // upper opcode bits shared by every memory access
   localparam logic [1:0] MEM_CLASS = 2'b11;
endpackage

// File: rtl/mlu_addr_gen.sv
module mlu_addr_gen
   import mlu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] reg_off,
   input  logic [IMM_W-1:0]  imm_off,
   input  logic              use_imm,
   input  size_e             size,
   output logic [ADDR_W-1:0] aligned,
   output logic [1:0]        lane_off
);
   localparam int EXT_W = ADDR_W - IMM_W;

   if (ADDR_W <= IMM_W) begin : g_bad_w
      $error("mlu_addr_gen: ADDR_W must exceed IMM_W");
   end

   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] ea;

   assign imm_ext = {{EXT_W{imm_off[IMM_W-1]}}, imm_off};
   assign ea      = base + (use_imm ? imm_ext : reg_off);

   always_comb begin
      aligned = ea;
      unique case (size)
         SZ_HALF: aligned[0]   = 1'b0;
         SZ_WORD: aligned[1:0] = 2'b00;
         default: aligned      = ea;
      endcase
   end

   assign lane_off = aligned[1:0];
endmodule

// File: rtl/mlu_store_lanes.sv
module mlu_store_lanes
   import mlu_pkg::*;
#(
   parameter int LANES      = 4,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic                 active,
   input  size_e                size,
   input  logic [1:0]           lane_off,
   input  logic [8*LANES-1:0]   data,
   output logic [LANES-1:0]     be,
   output logic [8*LANES-1:0]   wdata
);
   if (LANES != 4) begin : g_bad_lanes
      $error("mlu_store_lanes: LANES must be 4");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      // address position of this lane within the word
      localparam int POS = BIG_ENDIAN ? (LANES - 1 - k) : k;
      // which byte of a halfword lands on this lane
      localparam int HB  = BIG_ENDIAN ? (1 - (POS % 2)) : (POS % 2);
      localparam logic [1:0] POS2 = 2'(POS);

      always_comb begin
         be[k]          = 1'b0;
         wdata[8*k +: 8] = data[8*k +: 8];
         unique case (size)
            SZ_BYTE: begin
               be[k]          = active && (lane_off == POS2);
               wdata[8*k +: 8] = data[7:0];
            end
            SZ_HALF: begin
               be[k]          = active && (lane_off[1] == POS2[1]);
               wdata[8*k +: 8] = data[8*HB +: 8];
            end
            SZ_WORD: be[k]  = active;
            default: be[k]  = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/mlu_load_extract.sv
module mlu_load_extract
   import mlu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  size_e              size,
   input  logic [1:0]         lane_off,
   input  logic [DATA_W-1:0]  rdata,
   output logic [DATA_W-1:0]  result
);
   if (DATA_W != 32) begin : g_bad_data
      $error("mlu_load_extract: DATA_W must be 32");
   end

   logic [1:0] byte_lane;
   logic       half_sel;

   if (BIG_ENDIAN) begin : g_big
      assign byte_lane = 2'd3 - lane_off;
      assign half_sel  = ~lane_off[1];
   end else begin : g_little
      assign byte_lane = lane_off;
      assign half_sel  = lane_off[1];
   end

   logic [4:0] byte_bit;
   logic [4:0] half_bit;
   assign byte_bit = {byte_lane, 3'b000};
   assign half_bit = {half_sel, 4'b0000};

   always_comb begin
      unique case (size)
         SZ_BYTE: result = {{(DATA_W-8){1'b0}},  rdata[byte_bit +: 8]};
         SZ_HALF: result = {{(DATA_W-16){1'b0}}, rdata[half_bit +: 16]};
         default: result = rdata;
      endcase
   end
endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
   import mlu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter int OP_W       = 6,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [OP_W-1:0]   opcode,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] reg_off,
   input  logic [IMM_W-1:0]  imm_off,
   input  logic [DATA_W-1:0] store_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              load_valid,
   output logic [DATA_W-1:0] load_data
);
   localparam int LANES = DATA_W / 8;

   if (OP_W != 6) begin : g_bad_op
      $error("mem_lane_unit: OP_W must be 6");
   end

   // opcode decode
   size_e req_size;
   logic  is_store, use_imm, legal;
   assign req_size = size_e'(opcode[1:0]);
   assign is_store = opcode[2];
   assign use_imm  = opcode[3];
   assign legal    = req_valid && (opcode[5:4] == MEM_CLASS) && (req_size != SZ_NONE);

   // outstanding load bookkeeping
   logic       pend_q;
   size_e      pend_size_q;
   logic [1:0] pend_off_q;

   assign mem_req = legal && !pend_q;
   assign mem_we  = is_store;

   logic [1:0] lane_off;

   mlu_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
      .base     (base_val),
      .reg_off  (reg_off),
      .imm_off  (imm_off),
      .use_imm  (use_imm),
      .size     (req_size),
      .aligned  (mem_addr),
      .lane_off (lane_off)
   );

   mlu_store_lanes #(.LANES(LANES), .BIG_ENDIAN(BIG_ENDIAN)) u_store (
      .active   (mem_req),
      .size     (req_size),
      .lane_off (lane_off),
      .data     (store_data),
      .be       (mem_be),
      .wdata    (mem_wdata)
   );

   logic [DATA_W-1:0] extracted;

   mlu_load_extract #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_load (
      .size     (pend_size_q),
      .lane_off (pend_off_q),
      .rdata    (mem_rdata),
      .result   (extracted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_size_q <= SZ_BYTE;
         pend_off_q  <= 2'b00;
         load_valid  <= 1'b0;
         load_data   <= '0;
      end else begin
         load_valid <= 1'b0;
         if (mem_req && !is_store) begin
            pend_q      <= 1'b1;
            pend_size_q <= req_size;
            pend_off_q  <= lane_off;
         end else if (pend_q && mem_ready) begin
            pend_q     <= 1'b0;
            load_valid <= 1'b1;
            load_data  <= extracted;
         end
      end
   end
endmodule

// File: rtl/mem_lane_unit_chk.sv
module mem_lane_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [5:0]  opcode,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [3:0]  mem_be,
   input logic        mem_ready,
   input logic        load_valid
);
   // R1: malformed size code never reaches memory
   a_r1_bad_size_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && opcode[1:0] == 2'b11) |-> (!mem_req && mem_be == 4'b0000));

   // R1: no enables without a request
   a_r1_idle_no_be: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> mem_be == 4'b0000);

   // R4: halfword aligned, two lanes
   a_r4_half_align: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && opcode[1:0] == 2'b01) |-> (!mem_addr[0] && $countones(mem_be) == 2));

   // R4: word aligned, all lanes
   a_r4_word_align: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && opcode[1:0] == 2'b10) |-> (mem_addr[1:0] == 2'b00 && mem_be == 4'b1111));

   // R5: byte uses one lane
   a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && opcode[1:0] == 2'b00) |-> $countones(mem_be) == 1);

   // R8: valid is a single-cycle pulse
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |=> !load_valid);

   // R8: valid follows a sampled ready
   a_r8_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_valid) |-> $past(mem_ready));

   // R9: an issued load blocks the next cycle's request
   a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !mem_req);
endmodule

bind mem_lane_unit mem_lane_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .opcode     (opcode),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_be     (mem_be),
   .mem_ready  (mem_ready),
   .load_valid (load_valid)
);

// File: tb/mem_lane_unit_test.sv
module mem_lane_unit_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  opcode = 6'h00;
   logic [31:0] base_val = '0;
   logic [31:0] reg_off = '0;
   logic [15:0] imm_off = '0;
   logic [31:0] store_data = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        load_valid;
   logic [31:0] load_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   mem_lane_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
      .base_val(base_val), .reg_off(reg_off), .imm_off(imm_off),
      .store_data(store_data), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .load_valid(load_valid), .load_data(load_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] op, input logic [31:0] b, input logic [31:0] r,
                        input logic [15:0] i, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; opcode = op; base_val = b; reg_off = r; imm_off = i; store_data = d;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      #1;
      chk("R10 mem_req", {31'b0, mem_req}, 32'd0);
      chk("R10 load_valid", {31'b0, load_valid}, 32'd0);
      chk("R10 load_data", load_data, 32'd0);
   endtask

   task automatic t_store_byte();
      drive(6'h34, 32'h1000, 32'd5, 16'h0, 32'h123456A5);
      chk("R2/R3 byte addr", mem_addr, 32'h1005);
      chk("R5 byte be off1", {28'b0, mem_be}, 32'h4);
      chk("R6 byte wdata", mem_wdata, 32'hA5A5A5A5);
      chk("R6 we", {31'b0, mem_we}, 32'd1);
      idle();
   endtask

   task automatic t_store_half_imm();
      drive(6'h3D, 32'h2000, 32'h55, 16'hFFFF, 32'hCAFEBEEF);
      chk("R2/R4 half imm addr", mem_addr, 32'h1FFE);
      chk("R5 half be off2", {28'b0, mem_be}, 32'h3);
      chk("R6 half wdata", mem_wdata, 32'hBEEFBEEF);
      idle();
   endtask

   task automatic t_store_word();
      drive(6'h36, 32'h3000, 32'd7, 16'h0, 32'h01234567);
      chk("R4 word addr", mem_addr, 32'h3004);
      chk("R5 word be", {28'b0, mem_be}, 32'hF);
      chk("R6 word wdata", mem_wdata, 32'h01234567);
      idle();
   endtask

   task automatic do_load(input string tag, input logic [5:0] op, input logic [31:0] b,
                          input logic [31:0] r, input logic [15:0] i, input logic [31:0] rd,
                          input logic [31:0] ea, input logic [3:0] be, input logic [31:0] res);
      drive(op, b, r, i, 32'h0);
      chk({tag, " req"}, {31'b0, mem_req}, 32'd1);
      chk({tag, " we"}, {31'b0, mem_we}, 32'd0);
      chk({tag, " addr"}, mem_addr, ea);
      chk({tag, " be"}, {28'b0, mem_be}, {28'b0, be});
      @(negedge clk);
      req_valid = 1'b0; mem_ready = 1'b1; mem_rdata = rd;
      @(negedge clk);
      mem_ready = 1'b0; mem_rdata = 32'hFFFFFFFF;
      #1;
      chk({tag, " R8 valid"}, {31'b0, load_valid}, 32'd1);
      chk({tag, " R7 data"}, load_data, res);
      @(negedge clk);
      #1;
      chk({tag, " R8 pulse end"}, {31'b0, load_valid}, 32'd0);
      chk({tag, " R8 data hold"}, load_data, res);
   endtask

   task automatic t_loads();
      do_load("R7 byte off3", 6'h38, 32'h100, 32'h0, 16'd3, 32'h11223344, 32'h103, 4'b0001, 32'h44);
      do_load("R7 byte off0", 6'h30, 32'h200, 32'h0, 16'h0, 32'h91223344, 32'h200, 4'b1000, 32'h91);
      do_load("R7 half off2", 6'h31, 32'h40,  32'd3, 16'h0, 32'h8899AABB, 32'h42,  4'b0011, 32'h0000AABB);
      do_load("R7 half off0", 6'h39, 32'h40,  32'h0, 16'd1, 32'h8899AABB, 32'h40,  4'b1100, 32'h00008899);
      do_load("R7 word", 6'h3A, 32'h10, 32'h0, 16'd2, 32'hDEADBEEF, 32'h10, 4'b1111, 32'hDEADBEEF);
   endtask

   task automatic t_illegal();
      drive(6'h37, 32'h100, 32'h0, 16'h0, 32'h0);
      chk("R1 size 11 req", {31'b0, mem_req}, 32'd0);
      chk("R1 size 11 be", {28'b0, mem_be}, 32'd0);
      drive(6'h24, 32'h100, 32'h0, 16'h0, 32'h0);
      chk("R1 class req", {31'b0, mem_req}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0; opcode = 6'h36;
      #1;
      chk("R1 no valid req", {31'b0, mem_req}, 32'd0);
   endtask

   task automatic t_pending();
      drive(6'h32, 32'h500, 32'h0, 16'h0, 32'h0);
      chk("R9 first req", {31'b0, mem_req}, 32'd1);
      drive(6'h36, 32'h600, 32'h0, 16'h0, 32'hAAAA5555);
      chk("R9 held off store", {31'b0, mem_req}, 32'd0);
      chk("R9 held off be", {28'b0, mem_be}, 32'd0);
      @(negedge clk); #1;
      chk("R9 still held", {31'b0, mem_req}, 32'd0);
      chk("R8 no early valid", {31'b0, load_valid}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0; mem_ready = 1'b1; mem_rdata = 32'h0BADF00D;
      @(negedge clk);
      mem_ready = 1'b0;
      #1;
      chk("R8 late valid", {31'b0, load_valid}, 32'd1);
      chk("R7 late data", load_data, 32'h0BADF00D);
      @(negedge clk);
      mem_ready = 1'b1; mem_rdata = 32'h12345678;
      @(negedge clk);
      mem_ready = 1'b0;
      #1;
      chk("R9 stray ready valid", {31'b0, load_valid}, 32'd0);
      chk("R9 stray ready data", load_data, 32'h0BADF00D);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_store_byte();
      t_store_half_imm();
      t_store_word();
      t_loads();
      t_illegal();
      t_pending();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule